// File: doc/BRIEF.md
# Dual-Port Memory Sleep Controller

This block holds the sleep logic for both ports of a synchronous dual-ported memory. Each port has its own asynchronous sleep request, a chip-select pair, read and write strobes, an address, write data, and a read-data output with an output-enable. The two ports share one clock. When a port's request rises, the port stops accepting commands and floats its data outputs within a fixed number of cycles. When the request falls, the port passes through a recovery window before it accepts commands again. When both ports are asleep, a device-level low-current flag is raised.

A per-port sticky status flag records when the guard rules around sleep are broken. Those rules require deselect cycles before sleep begins and no select cycles during recovery. The storage is a small behavioural register file shared by both ports, and sleep leaves its contents unchanged. High impedance is shown as the output-enable being low, with the read-data bus forced to zero.

Top module: `snzDualPortTop`

## Requirements
- R1: After reset every port is awake, `dataOe` and `rdData` are zero, `guardErr` is zero and `lowCurrent` is zero.
- R2: A port is selected only when its `ce0N` is 0 and its `ce1` is 1. A read or write sampled under any of the other three combinations has no effect.
- R3: An accepted write stores `wrData` at `addr`. An accepted read drives `dataOe` high and `rdData` with the stored word after the same clock edge that samples it, for one cycle. Either port can read what the other wrote.
- R4: When both ports write the same address at the same edge, port 0's data is stored.
- R5: If `sleepReq[p]` rises before clock edge E1, `portAsleep[p]` is still 0 after E1 and is 1 after E2. From E3 on, commands are ignored. While the port is asleep, `dataOe[p]` is 0 and `rdData[p]` is zero.
- R6: A write issued to a sleeping port leaves the stored contents unchanged.
- R7: If `sleepReq[p]` falls before edge E1, `portAsleep[p]` is 0 after E2. Commands at E3 and E4 form the recovery window and are ignored. A command at E5 is accepted.
- R8: At the edge where a port goes asleep, `guardErr[p]` is set if a select was sampled at that edge or at either of the two edges before it.
- R9: A select sampled during the recovery window sets `guardErr[p]`. The flag stays set until reset.
- R10: `lowCurrent` is 1 exactly while both ports are asleep.
- R11: Stored data written before sleep is read back unchanged after wake.
- R12: A port that sleeps or wakes does not change how the other port serves commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sleepReq | input | 2 | Per-port asynchronous sleep request, active high |
| ce0N | input | 2 | Per-port chip enable, active low |
| ce1 | input | 2 | Per-port chip enable, active high |
| rdEn | input | 2 | Per-port read strobe |
| wrEn | input | 2 | Per-port write strobe |
| addr | input | 2*AW | Per-port address |
| wrData | input | 2*DW | Per-port write data |
| rdData | output | 2*DW | Per-port read data, zero while not driven |
| dataOe | output | 2 | Per-port output enable |
| portAsleep | output | 2 | Per-port sleep state |
| guardErr | output | 2 | Per-port sticky guard-rule violation flag |
| lowCurrent | output | 1 | Both ports asleep |

## Verification
Suppose a port's sleep state machine is wrong, for example it leaves sleep one cycle early or skips the recovery window. The fault then shows at the ports within about five edges of the request change, because a read during recovery drives `dataOe`. A gating fault shows up later, at the first read-back after wake: a write made while asleep or during recovery changes what comes back. The bench therefore reads every address after the sleep intervals. A wrong guard counter shows as `guardErr` set after a clean entry, or left clear after a select placed just before the request.

// File: rtl/snzPkg.sv
package snzPkg;
  localparam int NPORT = 2;

  typedef enum logic [1:0] {
    ST_AWAKE   = 2'd0,
    ST_SLEEP   = 2'd1,
    ST_RECOVER = 2'd2
  } snzState_t;

  // strobes from one port's control to the shared datapath
  typedef struct packed {
    logic cmdEn;   // commands may be sampled
    logic outEn;   // outputs may be driven
  } snzStrobe_t;

  function automatic logic isSelected(input logic ce0N, input logic ce1);
    return !ce0N && ce1;
  endfunction
endpackage

// File: rtl/snzPortCtrl.sv
module snzPortCtrl
  import snzPkg::*;
#(
  parameter int GUARD = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sleepReq,
  input  logic       ce0N,
  input  logic       ce1,
  output snzStrobe_t strobe,
  output logic       asleep,
  output logic       guardErr
);
  localparam int CW = $clog2(GUARD + 1);
  localparam logic [CW-1:0] GUARD_C = CW'(GUARD);
  localparam logic [CW-1:0] RECOV_LOAD = CW'(GUARD - 1);

  snzState_t     state;
  logic          reqMeta;
  logic [CW-1:0] dsCount;
  logic [CW-1:0] recCnt;
  logic          sel;

  assign sel = isSelected(ce0N, ce1);

  // first synchronizer flop; the state register acts as the second
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) reqMeta <= 1'b0;
    else       reqMeta <= sleepReq;
  end

  // run of consecutive deselect edges, saturating at GUARD
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                dsCount <= '0;
    else if (sel)             dsCount <= '0;
    else if (dsCount != GUARD_C) dsCount <= dsCount + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_AWAKE;
      recCnt   <= '0;
      guardErr <= 1'b0;
    end else begin
      case (state)
        ST_AWAKE: begin
          if (reqMeta) begin
            state <= ST_SLEEP;
            if (sel || (dsCount < GUARD_C)) guardErr <= 1'b1;
          end
        end
        ST_SLEEP: begin
          if (!reqMeta) begin
            state  <= ST_RECOVER;
            recCnt <= RECOV_LOAD;
          end
        end
        ST_RECOVER: begin
          if (sel) guardErr <= 1'b1;
          if (reqMeta)             state  <= ST_SLEEP;
          else if (recCnt == '0)   state  <= ST_AWAKE;
          else                     recCnt <= recCnt - 1'b1;
        end
        default: state <= ST_AWAKE;
      endcase
    end
  end

  always_comb begin
    strobe.cmdEn = (state == ST_AWAKE);
    strobe.outEn = (state != ST_SLEEP);
    asleep       = (state == ST_SLEEP);
  end
endmodule

// File: rtl/snzDatapath.sv
module snzDatapath
  import snzPkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  snzStrobe_t [NPORT-1:0]      strobe,
  input  logic [NPORT-1:0]            ce0N,
  input  logic [NPORT-1:0]            ce1,
  input  logic [NPORT-1:0]            rdEn,
  input  logic [NPORT-1:0]            wrEn,
  input  logic [NPORT-1:0][AW-1:0]    addr,
  input  logic [NPORT-1:0][DW-1:0]    wrData,
  output logic [NPORT-1:0][DW-1:0]    rdData,
  output logic [NPORT-1:0]            dataOe
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0]          mem [DEPTH];
  logic [NPORT-1:0]       rdAcc;
  logic [NPORT-1:0]       wrAcc;
  logic [NPORT-1:0][DW-1:0] rdReg;
  logic [NPORT-1:0]       oeReg;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    logic acc;
    assign acc      = strobe[p].cmdEn && isSelected(ce0N[p], ce1[p]);
    assign rdAcc[p] = acc && rdEn[p];
    assign wrAcc[p] = acc && wrEn[p];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        rdReg[p] <= '0;
        oeReg[p] <= 1'b0;
      end else begin
        oeReg[p] <= rdAcc[p];
        if (rdAcc[p]) rdReg[p] <= mem[addr[p]];
      end
    end

    assign dataOe[p] = oeReg[p] && strobe[p].outEn;
    assign rdData[p] = dataOe[p] ? rdReg[p] : '0;
  end

  // highest port first so port 0 wins a same-address collision
  always_ff @(posedge clk) begin
    for (int p = NPORT - 1; p >= 0; p--) begin
      if (wrAcc[p]) mem[addr[p]] <= wrData[p];
    end
  end
endmodule

// File: rtl/snzDualPortTop.sv
module snzDualPortTop
  import snzPkg::*;
#(
  parameter int AW    = 4,
  parameter int DW    = 8,
  parameter int GUARD = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NPORT-1:0]         sleepReq,
  input  logic [NPORT-1:0]         ce0N,
  input  logic [NPORT-1:0]         ce1,
  input  logic [NPORT-1:0]         rdEn,
  input  logic [NPORT-1:0]         wrEn,
  input  logic [NPORT-1:0][AW-1:0] addr,
  input  logic [NPORT-1:0][DW-1:0] wrData,
  output logic [NPORT-1:0][DW-1:0] rdData,
  output logic [NPORT-1:0]         dataOe,
  output logic [NPORT-1:0]         portAsleep,
  output logic [NPORT-1:0]         guardErr,
  output logic                     lowCurrent
);
  snzStrobe_t [NPORT-1:0] strobe;

  for (genvar p = 0; p < NPORT; p++) begin : g_ctrl
    snzPortCtrl #(.GUARD(GUARD)) ctrl_i (
      .clk      (clk),
      .rstN     (rstN),
      .sleepReq (sleepReq[p]),
      .ce0N     (ce0N[p]),
      .ce1      (ce1[p]),
      .strobe   (strobe[p]),
      .asleep   (portAsleep[p]),
      .guardErr (guardErr[p])
    );
  end

  snzDatapath #(.AW(AW), .DW(DW)) dp_i (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .ce0N   (ce0N),
    .ce1    (ce1),
    .rdEn   (rdEn),
    .wrEn   (wrEn),
    .addr   (addr),
    .wrData (wrData),
    .rdData (rdData),
    .dataOe (dataOe)
  );

  assign lowCurrent = &portAsleep;
endmodule

// File: rtl/snzCheck.sv
module snzCheck
  import snzPkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input logic                     clk,
  input logic                     rstN,
  input logic [NPORT-1:0]         sleepReq,
  input logic [NPORT-1:0][DW-1:0] rdData,
  input logic [NPORT-1:0]         dataOe,
  input logic [NPORT-1:0]         portAsleep,
  input logic                     lowCurrent
);
  for (genvar p = 0; p < NPORT; p++) begin : g_chk
    // R5
    asleep_floats_chk: assert property (@(posedge clk) disable iff (!rstN)
      portAsleep[p] |-> !dataOe[p] && (rdData[p] == '0));

    // R5
    asleep_needs_req_chk: assert property (@(posedge clk) disable iff (!rstN)
      portAsleep[p] |-> $past(sleepReq[p], 2));

    // R7
    recovery_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
      $fell(portAsleep[p]) |-> !dataOe[p] ##1 !dataOe[p] ##1 !dataOe[p]);

    // R3
    data_only_when_driven_chk: assert property (@(posedge clk) disable iff (!rstN)
      (rdData[p] != '0) |-> dataOe[p]);
  end

  // R10
  low_current_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    lowCurrent |-> $past(sleepReq[0], 2) && $past(sleepReq[1], 2));
endmodule

bind snzDualPortTop snzCheck #(.AW(AW), .DW(DW)) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .sleepReq   (sleepReq),
  .rdData     (rdData),
  .dataOe     (dataOe),
  .portAsleep (portAsleep),
  .lowCurrent (lowCurrent)
);

// File: tb/snzDualPortTop_tb_top.sv
module snzDualPortTop_tb_top;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  logic                rstN;
  logic [1:0]          sleepReq, ce0N, ce1, rdEn, wrEn;
  logic [1:0][AW-1:0]  addr;
  logic [1:0][DW-1:0]  wrData;
  logic [1:0][DW-1:0]  rdData;
  logic [1:0]          dataOe, portAsleep, guardErr;
  logic                lowCurrent;

  snzDualPortTop #(.AW(AW), .DW(DW), .GUARD(2)) dut_i (
    .clk(clk), .rstN(rstN), .sleepReq(sleepReq), .ce0N(ce0N), .ce1(ce1),
    .rdEn(rdEn), .wrEn(wrEn), .addr(addr), .wrData(wrData), .rdData(rdData),
    .dataOe(dataOe), .portAsleep(portAsleep), .guardErr(guardErr),
    .lowCurrent(lowCurrent)
  );

  logic [DW-1:0] model [DEPTH];
  int nChk = 0;
  int nFail = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic idle(input int p);
    ce0N[p] = 1'b1; ce1[p] = 1'b0; rdEn[p] = 1'b0; wrEn[p] = 1'b0;
  endtask

  task automatic cmd(input int p, input bit c0n, input bit c1, input bit rd,
                     input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
    ce0N[p] = c0n; ce1[p] = c1; rdEn[p] = rd; wrEn[p] = wr;
    addr[p] = a; wrData[p] = d;
  endtask

  task automatic wrWord(input int p, input logic [AW-1:0] a, input logic [DW-1:0] d);
    cmd(p, 1'b0, 1'b1, 1'b0, 1'b1, a, d);
    tick();
    idle(p);
  endtask

  task automatic rdChk(input int p, input logic [AW-1:0] a, input logic [DW-1:0] exp,
                       input string tag);
    cmd(p, 1'b0, 1'b1, 1'b1, 1'b0, a, '0);
    tick();
    idle(p);
    chk(dataOe[p] && rdData[p] == exp, tag, {dataOe[p], rdData[p]}, {1'b1, exp});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChk++;
    nFail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finishRun();
  end

  initial begin
    rstN = 1'b0; sleepReq = '0; addr = '0; wrData = '0;
    idle(0); idle(1);
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    // R1 reset state
    chk(dataOe == 0 && rdData == 0 && portAsleep == 0 && guardErr == 0 && !lowCurrent,
        "R1 reset outputs", {dataOe, portAsleep, guardErr, lowCurrent}, 0);

    // R3 sweep: port 0 writes, port 1 reads, then the reverse
    for (int a = 0; a < DEPTH; a++) begin
      model[a] = DW'((a * 17) ^ 8'h5A);
      wrWord(0, AW'(a), model[a]);
    end
    for (int a = 0; a < DEPTH; a++) rdChk(1, AW'(a), model[a], "R3 port1 read");
    for (int a = 0; a < DEPTH; a++) begin
      model[a] = DW'((a * 29) + 8'h33);
      wrWord(1, AW'(a), model[a]);
    end
    for (int a = 0; a < DEPTH; a++) rdChk(0, AW'(a), model[a], "R3 port0 read");

    // R4 same-address collision
    cmd(0, 1'b0, 1'b1, 1'b0, 1'b1, AW'(9), 8'h11);
    cmd(1, 1'b0, 1'b1, 1'b0, 1'b1, AW'(9), 8'h22);
    tick();
    idle(0); idle(1);
    model[9] = 8'h11;
    rdChk(1, AW'(9), model[9], "R4 collision port0 wins");

    // R2 every chip-enable combination for write and read
    for (int c = 0; c < 4; c++) begin
      bit c0n, c1, selOk;
      c0n = c[0]; c1 = c[1];
      selOk = !c0n && c1;
      cmd(0, c0n, c1, 1'b0, 1'b1, AW'(3), DW'(8'hC0 + c));
      tick();
      idle(0);
      if (selOk) model[3] = DW'(8'hC0 + c);
      cmd(1, c0n, c1, 1'b1, 1'b0, AW'(3), '0);
      tick();
      idle(1);
      chk(dataOe[1] == selOk, "R2 read select decode", dataOe[1], selOk);
      rdChk(1, AW'(3), model[3], "R2 write select decode");
    end

    // R5 port 0 enters sleep after clean deselect run
    idle(0); idle(1);
    repeat (3) tick();
    sleepReq[0] = 1'b1;
    tick();
    chk(portAsleep[0] == 1'b0, "R5 awake after E1", portAsleep[0], 0);
    tick();
    chk(portAsleep[0] == 1'b1, "R5 asleep after E2", portAsleep[0], 1);
    chk(guardErr[0] == 1'b0, "R8 clean entry no flag", guardErr[0], 0);
    chk(lowCurrent == 1'b0, "R10 one port asleep", lowCurrent, 0);

    // R6 commands to sleeping port are ignored
    cmd(0, 1'b0, 1'b1, 1'b0, 1'b1, AW'(5), 8'hEE);
    tick();
    idle(0);
    cmd(0, 1'b0, 1'b1, 1'b1, 1'b0, AW'(5), '0);
    tick();
    idle(0);
    chk(dataOe[0] == 0 && rdData[0] == 0, "R5 asleep outputs floated",
        {dataOe[0], rdData[0]}, 0);
    rdChk(1, AW'(5), model[5], "R12 other port serves, R6 no write");

    // R10 both asleep
    tick(); tick();
    sleepReq[1] = 1'b1;
    tick(); tick();
    chk(lowCurrent == 1'b1 && portAsleep[1], "R10 both asleep", lowCurrent, 1);
    chk(guardErr[1] == 1'b0, "R8 clean entry port1", guardErr[1], 0);

    // R7 port 1 wakes with deselects in recovery
    sleepReq[1] = 1'b0;
    tick();
    chk(lowCurrent == 1'b1, "R10 still both asleep after E1", lowCurrent, 1);
    tick();
    chk(lowCurrent == 1'b0 && portAsleep[1] == 0, "R7 awake after E2, R10",
        {lowCurrent, portAsleep[1]}, 0);
    tick(); tick();
    rdChk(1, AW'(5), model[5], "R7 accepted at E5");
    chk(guardErr[1] == 1'b0, "R9 clean recovery no flag", guardErr[1], 0);

    // R9 / R7 port 0 wakes with selects inside recovery
    sleepReq[0] = 1'b0;
    tick(); tick();
    chk(portAsleep[0] == 1'b0, "R7 port0 awake after E2", portAsleep[0], 0);
    cmd(0, 1'b0, 1'b1, 1'b0, 1'b1, AW'(6), 8'h99);
    tick();
    idle(0);
    chk(guardErr[0] == 1'b1, "R9 select in recovery flagged", guardErr[0], 1);
    cmd(0, 1'b0, 1'b1, 1'b1, 1'b0, AW'(6), '0);
    tick();
    idle(0);
    chk(dataOe[0] == 1'b0, "R7 read at E4 ignored", dataOe[0], 0);
    rdChk(0, AW'(6), model[6], "R7 read at E5, recovery write ignored");
    rdChk(0, AW'(5), model[5], "R6 sleep write ignored");
    tick();
    chk(guardErr[0] == 1'b1, "R9 flag sticky", guardErr[0], 1);

    // R8 select just before request on port 1
    rdChk(1, AW'(2), model[2], "R3 read before sleep");
    sleepReq[1] = 1'b1;
    tick(); tick();
    chk(portAsleep[1] == 1'b1 && guardErr[1] == 1'b1, "R8 early select flagged",
        {portAsleep[1], guardErr[1]}, 2'b11);

    // R11 full contents preserved, read from awake port 0
    for (int a = 0; a < DEPTH; a++) rdChk(0, AW'(a), model[a], "R11 contents kept");

    finishRun();
  end
endmodule